// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Receiver

This block sits in front of a pair of 12-bit voltage converters. It takes 16-bit command words from a three-wire serial port (a frame strobe that is active low, a serial clock and a data line). It keeps one code register per channel and drives a shared power-down flag. All three serial lines are asynchronous to the system clock. Each line passes through a two-flop synchroniser, and the serial clock and frame strobe also pass through edge detection. The receiver therefore runs entirely in the system clock domain.

A command word carries a channel select in bit 15, a don't-care bit in bit 14, a power-down bit in bit 13, a reserved bit in bit 12 that must be zero, and a signed 12-bit value in bits 11..0. The channel is written as soon as the sixteenth bit arrives, without waiting for the frame strobe to rise. Each channel register holds an offset-binary code: the signed input with its top bit inverted, so that zero maps to mid-scale. The power-down flag is sticky. Only a normal command whose channel select matches the one that set the flag can clear it.

The receiver state machine has three states:
- `ST_IDLE` waits for a falling frame strobe. On that edge it takes the `T_OPEN` transition to `ST_SHIFT` and clears the bit counter.
- `ST_SHIFT` shifts one bit on every rising serial clock. If the strobe rises early, it takes `T_ABORT` back to `ST_IDLE`. When the sixteenth bit arrives, it takes `T_COMPLETE` to `ST_HOLD` and presents the word for one cycle.
- `ST_HOLD` ignores all further clocks. It takes `T_CLOSE` back to `ST_IDLE` once the strobe is high again.

Top module: `dual_dac_serial_if`

## Requirements
- R1: Bits are sampled on rising serial clock edges, most significant bit first. The first bit sampled in a frame becomes bit 15 of the command word.
- R2: A frame begins only on a falling edge of `cs_n`. Serial clocks while `cs_n` is high change nothing.
- R3: Bit 15 selects the channel: 0 selects A and 1 selects B. The selected channel's code updates after the sixteenth rising edge while `cs_n` is still low. The other channel keeps its code.
- R4: The stored code is the 12-bit data field with bit 11 inverted. For example, 0x7FF gives 0xFFF, 0x000 gives 0x800, 0x800 gives 0x000, and 0x123 gives 0x923.
- R5: Rising edges after the sixteenth within the same low period of `cs_n` are ignored. A new frame needs `cs_n` to go high and then low again.
- R6: A frame in which `cs_n` rises before the sixteenth edge is discarded. It changes no code, no flag and no strobe.
- R7: A command with bit 12 equal to 1 is rejected. It changes no code, no flag and no strobe.
- R8: A command with bit 13 equal to 1 sets `shutdown`, records its bit 15, and leaves both codes unchanged without any strobe. Bit 14 has no effect on any command.
- R9: A command with bit 13 equal to 0 always loads its channel. It clears `shutdown` only if its bit 15 equals the recorded select. Otherwise `shutdown` stays set.
- R10: After reset, both codes are 0x800, `shutdown` is 0, and both strobes are 0.
- R11: Each channel load raises that channel's update strobe for exactly one system clock. At most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial frame strobe, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data, asynchronous |
| code_a | output | 12 | Offset-binary code for channel A |
| code_b | output | 12 | Offset-binary code for channel B |
| shutdown | output | 1 | Shared power-down flag |
| upd_a | output | 1 | One-cycle pulse when channel A loads |
| upd_b | output | 1 | One-cycle pulse when channel B loads |

## Verification
The assertions assume the serial lines are slow relative to `clk`. Each level of `sclk` must last several system clocks, and `sdi` must be stable across each rising edge of `sclk` long enough for both synchronised copies to agree. The assertions also assume that `cs_n` does not change in the same synchronised cycle as a rising edge of `sclk`. The directed stimulus satisfies all of this. It holds every half period of `sclk` for four system clocks, changes `sdi` only while `sclk` is low, and waits several cycles around every edge of `cs_n`.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CODE_BITS  = 12;
    localparam int SEL_POS    = 15;
    localparam int PDN_POS    = 13;
    localparam int RSV_POS    = 12;
    localparam int NUM_CH     = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } rx_state_t;

    typedef logic [CODE_BITS-1:0] code_t;

    // signed field -> offset binary: invert the sign bit
    function automatic code_t to_offset(input code_t d);
        return {~d[CODE_BITS-1], d[CODE_BITS-2:0]};
    endfunction
endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = dsi_pkg::SYNC_STAGES,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
                prev_q  <= RST_VAL[b];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[b]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign level[b] = chain_q[STAGES-1];
        assign rise[b]  =  chain_q[STAGES-1] & ~prev_q;
        assign fall[b]  = ~chain_q[STAGES-1] &  prev_q;
    end
endmodule

// File: rtl/dsi_frame_rx.sv
module dsi_frame_rx
    import dsi_pkg::*;
#(
    parameter int NBITS = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_lvl,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_rise,
    input  logic             sdi_lvl,
    output logic             frame_vld,
    output logic [NBITS-1:0] frame_word
);
    localparam int CW = $clog2(NBITS);
    localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

    rx_state_t        state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [NBITS-1:0] shreg_q;
    logic             take_bit;

    assign take_bit = (state_q == ST_SHIFT) && sclk_rise && !cs_rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = ST_SHIFT;                // T_OPEN
            ST_SHIFT: begin
                if (cs_rise)                        state_d = ST_IDLE; // T_ABORT
                else if (take_bit && cnt_q == LAST) state_d = ST_HOLD; // T_COMPLETE
            end
            ST_HOLD:  if (cs_lvl) state_d = ST_IDLE;                  // T_CLOSE
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            shreg_q    <= '0;
            frame_vld  <= 1'b0;
            frame_word <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (state_q == ST_IDLE && cs_fall) begin
                cnt_q <= '0;
            end else if (take_bit) begin
                shreg_q <= {shreg_q[NBITS-2:0], sdi_lvl};
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    frame_vld  <= 1'b1;
                    frame_word <= {shreg_q[NBITS-2:0], sdi_lvl};
                end
            end
        end
    end

    assert_word_at_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> state_q == ST_HOLD);
    assert_single_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);
    assert_hold_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !cs_lvl) |=> !frame_vld);
    assert_abort_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_rise) |=> (!frame_vld && state_q == ST_IDLE));
    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !frame_vld);
endmodule

// File: rtl/dsi_chan_bank.sv
module dsi_chan_bank
    import dsi_pkg::*;
#(
    parameter int NBITS = FRAME_BITS,
    parameter int CB    = CODE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_vld,
    input  logic [NBITS-1:0]   frame_word,
    output logic [NUM_CH*CB-1:0] codes,
    output logic [NUM_CH-1:0]  upd,
    output logic               shutdown
);
    localparam code_t MID = code_t'(1) << (CB - 1);

    logic   sel, pdn, rsv, accept, load;
    code_t  data;
    logic   pdn_q, pdn_sel_q;
    logic   unused_dc;

    assign sel    = frame_word[SEL_POS];
    assign pdn    = frame_word[PDN_POS];
    assign rsv    = frame_word[RSV_POS];
    assign data   = frame_word[CB-1:0];
    assign accept = frame_vld && !rsv;
    assign load   = accept && !pdn;
    assign unused_dc = frame_word[SEL_POS-1];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic MY_SEL = (c != 0);
        code_t code_r;
        logic  upd_r;
        logic  hit;

        assign hit = load && (sel == MY_SEL);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_r <= MID;
                upd_r  <= 1'b0;
            end else begin
                upd_r <= hit;
                if (hit) code_r <= to_offset(data);
            end
        end

        assign codes[c*CB +: CB] = code_r;
        assign upd[c]            = upd_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pdn_q     <= 1'b0;
            pdn_sel_q <= 1'b0;
        end else if (accept) begin
            if (pdn) begin
                pdn_q     <= 1'b1;
                pdn_sel_q <= sel;
            end else if (pdn_q && sel == pdn_sel_q) begin
                pdn_q <= 1'b0;
            end
        end
    end

    assign shutdown = pdn_q;

    assert_reject_rsv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && rsv) |=> ($stable(codes) && $stable(shutdown) && upd == '0));
    assert_pdn_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && pdn) |=> (upd == '0 && $stable(codes)));
    assert_pdn_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && pdn && !rsv) |=> shutdown);
    assert_wrong_sel_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && frame_vld && sel != pdn_sel_q) |=> shutdown);
    assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd));
    assert_strobe_needs_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd != '0) |-> $past(frame_vld));
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
    import dsi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdi,
    output logic [CODE_BITS-1:0] code_a,
    output logic [CODE_BITS-1:0] code_b,
    output logic                 shutdown,
    output logic                 upd_a,
    output logic                 upd_b
);
    // bit order in the synchroniser: [2]=cs_n, [1]=sclk, [0]=sdi
    logic [2:0] s_lvl, s_rise, s_fall;
    logic       unused_edges;
    logic                    frame_vld;
    logic [FRAME_BITS-1:0]   frame_word;
    logic [NUM_CH*CODE_BITS-1:0] codes;
    logic [NUM_CH-1:0]       upd;

    dsi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sclk, sdi}),
        .level    (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    assign unused_edges = ^{s_rise[0], s_fall[0], s_fall[1]};

    dsi_frame_rx #(.NBITS(FRAME_BITS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_lvl     (s_lvl[2]),
        .cs_fall    (s_fall[2]),
        .cs_rise    (s_rise[2]),
        .sclk_rise  (s_rise[1]),
        .sdi_lvl    (s_lvl[0]),
        .frame_vld  (frame_vld),
        .frame_word (frame_word)
    );

    dsi_chan_bank #(.NBITS(FRAME_BITS), .CB(CODE_BITS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame_word (frame_word),
        .codes      (codes),
        .upd        (upd),
        .shutdown   (shutdown)
    );

    assign code_a = codes[0 +: CODE_BITS];
    assign code_b = codes[CODE_BITS +: CODE_BITS];
    assign upd_a  = upd[0];
    assign upd_b  = upd[1];

    assert_a_moves_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_a |-> $stable(code_a));
    assert_b_moves_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_b |-> $stable(code_b));
endmodule

// File: tb/dual_dac_serial_if_test.sv
module dual_dac_serial_if_test;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [11:0] code_a, code_b;
    logic        shutdown, upd_a, upd_b;

    int n_chk = 0;
    int n_bad = 0;
    int na = 0;
    int nb = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_dac_serial_if uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .code_a(code_a), .code_b(code_b), .shutdown(shutdown),
        .upd_a(upd_a), .upd_b(upd_b)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_a) na++;
            if (upd_b) nb++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [15:0] w, input int n);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 15; i > 15 - n; i--) begin
            sdi = w[i]; sclk = 1'b0; idle(HALF);
            sclk = 1'b1; idle(HALF);
        end
        sclk = 1'b0;
        idle(HALF + 4);
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        idle(8);
    endtask

    task automatic send(input logic [15:0] w);
        shift_bits(w, 16);
        end_frame();
    endtask

    task automatic t_reset();
        chk("R10 code_a", code_a, 12'h800);
        chk("R10 code_b", code_b, 12'h800);
        chk("R10 shutdown", shutdown, 0);
        chk("R10 strobes", {upd_a, upd_b}, 0);
    endtask

    task automatic t_idle_clocks();
        for (int i = 0; i < 20; i++) begin
            sdi = i[0]; sclk = 1'b1; idle(HALF); sclk = 1'b0; idle(HALF);
        end
        chk("R2 no frame without cs fall A", code_a, 12'h800);
        chk("R2 no frame without cs fall B", code_b, 12'h800);
        chk("R2 no strobe", na + nb, 0);
    endtask

    task automatic t_write_a();
        shift_bits(16'h0123, 16);
        chk("R3 A loaded while cs low", code_a, 12'h923);
        chk("R1 msb first order", code_a, 12'h923);
        chk("R3 B untouched", code_b, 12'h800);
        chk("R11 one strobe A", na, 1);
        end_frame();
        send(16'h07FF);
        chk("R4 0x7FF -> 0xFFF", code_a, 12'hFFF);
        chk("R11 strobe A count", na, 2);
        chk("R11 no strobe B", nb, 0);
    endtask

    task automatic t_write_b();
        send(16'h8800);
        chk("R4 0x800 -> 0x000", code_b, 12'h000);
        chk("R3 A kept", code_a, 12'hFFF);
        send(16'h8000);
        chk("R4 0x000 -> 0x800", code_b, 12'h800);
        chk("R11 strobe B count", nb, 2);
    endtask

    task automatic t_extra_edges();
        int a0 = na; int b0 = nb;
        shift_bits(16'h0155, 16);
        shift_bits(16'hFFFF, 16);
        chk("R5 extra edges ignored A", code_a, 12'h955);
        chk("R5 extra edges ignored B", code_b, 12'h800);
        chk("R5 single strobe", (na - a0) + (nb - b0), 1);
        end_frame();
        send(16'h8456);
        chk("R5 next frame after cs high", code_b, 12'hC56);
    endtask

    task automatic t_short();
        int a0 = na; int b0 = nb;
        shift_bits(16'h0000, 10);
        end_frame();
        chk("R6 short frame A", code_a, 12'h955);
        chk("R6 short frame B", code_b, 12'hC56);
        chk("R6 no strobe", (na - a0) + (nb - b0), 0);
        send(16'h0001);
        chk("R6 recovery", code_a, 12'h801);
    endtask

    task automatic t_rsv();
        int a0 = na; int b0 = nb;
        send(16'h1FFF);
        send(16'h3000);
        chk("R7 rsv bit rejected A", code_a, 12'h801);
        chk("R7 rsv bit no shutdown", shutdown, 0);
        chk("R7 no strobe", (na - a0) + (nb - b0), 0);
    endtask

    task automatic t_pdn();
        int a0 = na; int b0 = nb;
        send(16'h4321);
        chk("R8 bit14 ignored", code_a, 12'hB21);
        a0 = na;
        send(16'hE0AB);
        chk("R8 shutdown set", shutdown, 1);
        chk("R8 A kept", code_a, 12'hB21);
        chk("R8 B kept", code_b, 12'hC56);
        chk("R8 no strobe", (na - a0) + (nb - b0), 0);
        send(16'h0010);
        chk("R9 mismatched select loads", code_a, 12'h810);
        chk("R9 mismatched select keeps shutdown", shutdown, 1);
        send(16'h87F0);
        chk("R9 matching select loads", code_b, 12'hFF0);
        chk("R9 matching select releases", shutdown, 0);
    endtask

    initial begin
        idle(5);
        t_reset();
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_idle_clocks();
        idle(10);
        t_write_a();
        t_write_b();
        t_extra_edges();
        t_short();
        t_rsv();
        t_pdn();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule